// File: doc/BRIEF.md
# Serial GPIO Bitstream Controller

This block drives a daisy chain of external shift registers that extend a chip's general purpose pins. Each of up to 32 ports owns 1 to 4 output bits and 1 to 4 input bits. In every burst the engine shifts the output values of the enabled ports out on a serial data line, one bit per serial clock period. It samples the returning serial input line during the same period. After the last bit it pulses a load strobe so that the external registers latch their outputs together. The captured inputs are then published to software.

Software reaches the block through a flat 32-bit register bus with a write strobe, a word address and a combinational read port. Bursts either repeat on their own with a programmable idle gap between them, or run once on request. A one-shot request is cleared by the hardware when its burst is over, but only while automatic repetition is off. The serial clock is derived from the system clock by an integer divider.

Top module: `sio_chain_ctrl`

## Requirements
- R1: After reset every register and input word reads 0, and sio_clk, sio_load and sio_dout stay low while no burst runs.
- R2: Config word (address 0x00) bits [1:0] hold the bits-per-port count minus one. Each enabled port sends exactly that many plus one bits per burst.
- R3: Port word p (address 0x40+p) keeps bits [23:12] as four 3-bit fields, field n at bit 12+3n. Only the lowest bit of field n drives output bit n. Bits outside [23:12] read back 0.
- R4: Ports that are clear in the enable mask are skipped entirely. Bits go out port by port in ascending order, and within a port from bit 0 upward. With no port enabled, a burst is only a load strobe.
- R5: The clock word (address 0x01) holds the divide value d in bits [19:8]. One serial period lasts max(2,d) system cycles. sio_clk is high for the last max(2,d) minus floor(max(2,d)/2) cycles of each shift period, and sio_dout only changes while sio_clk is low.
- R6: After the last bit, sio_load is high for exactly one serial period, and sio_clk stays low during that period.
- R7: Input word b (address 0x08+b) bit p holds sio_din as sampled during bit b of port p. Disabled ports and bits beyond the configured width read 0. The words change only at the end of the load strobe.
- R8: Config bit 2 (auto-repeat) runs bursts back to back. The first sio_clk rise of the next burst comes (g+1)*max(2,d)+floor(max(2,d)/2) cycles after sio_load falls, where g is config bits [23:16]. Once the bit is cleared, bursts stop.
- R9: Writing config bit 3 (single-shot) with auto-repeat off starts one burst. The bit reads 1 until that burst's load strobe ends and then reads 0.
- R10: While auto-repeat is set, the single-shot bit is never cleared by hardware.
- R11: Port words written during a burst do not change that burst's output, and they take effect in the next burst.
- R12: The enable mask lives at address 0x02 and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sio_clk | output | 1 | Serial clock |
| sio_dout | output | 1 | Serial output data |
| sio_din | input | 1 | Serial input data |
| sio_load | output | 1 | Load strobe at the end of each burst |

## Verification
The bench loops the serial output back to the input and uses a sparse enable mask that includes port 31 and leaves gaps. A design that walked disabled ports, sent bits in the wrong order, or read the wrong bit of a source field would produce a mismatched bit stream and wrong input words. Port words are rewritten in the middle of a slow burst, so a design that read live settings instead of a snapshot would leak new values into the current stream. Forcing the input line high and reading an input word while the load strobe is high catches early publication of captured data. Timed measurements of the clock high phase, the strobe width, the divider floor of 2 and the repeat gap, together with the single-shot bit under both repeat settings and an all-disabled burst, cover the off-by-one and clearing mistakes that a wrong sequencer would make.

// File: rtl/sio_chain_ctrl.sv
module sio_chain_ctrl #(
  parameter int NPORT = 32,
  parameter int MAXB  = 4,
  parameter int DIVW  = 12,
  parameter int GAPW  = 8,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          sio_clk,
  output logic          sio_dout,
  input  logic          sio_din,
  output logic          sio_load
);
  localparam int PW = $clog2(NPORT);
  localparam int BW = $clog2(MAXB);
  localparam int FW = 3 * MAXB;
  localparam logic [AW-1:0] A_CFG = 0;
  localparam logic [AW-1:0] A_CLK = 1;
  localparam logic [AW-1:0] A_ENA = 2;
  localparam logic [AW-1:0] IN_LO = 8;
  localparam logic [AW-1:0] IN_HI = 8 + MAXB;
  localparam logic [AW-1:0] PC_LO = 64;
  localparam logic [AW-1:0] PC_HI = 64 + NPORT;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LOAD, S_GAP} st_t;
  st_t st;

  logic [BW-1:0]    cfg_w, snap_w, b_q;
  logic             cfg_ar, cfg_ss, ss_taken;
  logic [GAPW-1:0]  cfg_gap, gap_q;
  logic [DIVW-1:0]  div_q, cnt, div_eff;
  logic [NPORT-1:0] en_q, snap_en;
  logic [PW-1:0]    p_q;
  logic [FW-1:0]    pcfg [NPORT];
  logic [MAXB-1:0]  cur_val [NPORT];
  logic [MAXB-1:0]  snap [NPORT];
  logic [NPORT-1:0] shd [MAXB];
  logic [NPORT-1:0] inw [MAXB];
  logic [PW:0]      nx_first, nx_after;
  logic             tick, cfg_wr_hit, in_idle;

  function automatic logic [PW:0] seek(input logic [NPORT-1:0] m, input int from);
    seek = '0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (i >= from && m[i]) seek = {1'b1, PW'(i)};
  endfunction

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    for (genvar b = 0; b < MAXB; b++) begin : g_bit
      assign cur_val[p][b] = pcfg[p][3*b];
    end
  end

  assign div_eff    = (div_q < DIVW'(2)) ? DIVW'(2) : div_q;
  assign tick       = cnt >= div_eff - DIVW'(1);
  assign nx_first   = seek(en_q, 0);
  assign nx_after   = seek(snap_en, int'(p_q) + 1);
  assign sio_clk    = (st == S_SHIFT) && (cnt >= (div_eff >> 1));
  assign sio_load   = (st == S_LOAD);
  assign sio_dout   = (st == S_SHIFT) ? snap[p_q][b_q] : 1'b0;
  assign cfg_wr_hit = bus_wr && (bus_addr == A_CFG);
  assign in_idle    = (st == S_IDLE);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CFG) begin
      bus_rdata[BW-1:0]      = cfg_w;
      bus_rdata[2]           = cfg_ar;
      bus_rdata[3]           = cfg_ss;
      bus_rdata[16 +: GAPW]  = cfg_gap;
    end else if (bus_addr == A_CLK) begin
      bus_rdata[8 +: DIVW]   = div_q;
    end else if (bus_addr == A_ENA) begin
      bus_rdata[NPORT-1:0]   = en_q;
    end else if (bus_addr >= IN_LO && bus_addr < IN_HI) begin
      bus_rdata[NPORT-1:0]   = inw[BW'(bus_addr - IN_LO)];
    end else if (bus_addr >= PC_LO && bus_addr < PC_HI) begin
      bus_rdata[12 +: FW]    = pcfg[PW'(bus_addr - PC_LO)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cfg_w <= '0; cfg_ar <= 1'b0; cfg_ss <= 1'b0; cfg_gap <= '0;
      div_q <= '0; en_q <= '0; cnt <= '0;
      snap_w <= '0; snap_en <= '0; p_q <= '0; b_q <= '0;
      gap_q <= '0; ss_taken <= 1'b0;
      for (int i = 0; i < NPORT; i++) begin
        pcfg[i] <= '0;
        snap[i] <= '0;
      end
      for (int i = 0; i < MAXB; i++) begin
        shd[i] <= '0;
        inw[i] <= '0;
      end
    end else begin
      cnt <= tick ? '0 : cnt + DIVW'(1);
      if (tick) begin
        case (st)
          S_IDLE: if (cfg_ar || cfg_ss) begin
            snap_en  <= en_q;
            snap_w   <= cfg_w;
            ss_taken <= cfg_ss;
            for (int i = 0; i < NPORT; i++) snap[i] <= cur_val[i];
            for (int i = 0; i < MAXB; i++) shd[i] <= '0;
            p_q <= nx_first[PW-1:0];
            b_q <= '0;
            st  <= nx_first[PW] ? S_SHIFT : S_LOAD;
          end
          S_SHIFT: begin
            shd[b_q][p_q] <= sio_din;
            if (b_q != snap_w) begin
              b_q <= b_q + BW'(1);
            end else if (nx_after[PW]) begin
              p_q <= nx_after[PW-1:0];
              b_q <= '0;
            end else begin
              st <= S_LOAD;
            end
          end
          S_LOAD: begin
            for (int i = 0; i < MAXB; i++) inw[i] <= shd[i];
            if (ss_taken && !cfg_ar) cfg_ss <= 1'b0;
            ss_taken <= 1'b0;
            if (cfg_gap != '0) begin
              gap_q <= cfg_gap - GAPW'(1);
              st    <= S_GAP;
            end else begin
              st <= S_IDLE;
            end
          end
          default: begin
            if (gap_q == '0) st <= S_IDLE;
            else gap_q <= gap_q - GAPW'(1);
          end
        endcase
      end
      if (bus_wr) begin
        if (bus_addr == A_CFG) begin
          cfg_w   <= bus_wdata[BW-1:0];
          cfg_ar  <= bus_wdata[2];
          cfg_ss  <= bus_wdata[3];
          cfg_gap <= bus_wdata[16 +: GAPW];
        end else if (bus_addr == A_CLK) begin
          div_q <= bus_wdata[8 +: DIVW];
        end else if (bus_addr == A_ENA) begin
          en_q <= bus_wdata[NPORT-1:0];
        end else if (bus_addr >= PC_LO && bus_addr < PC_HI) begin
          pcfg[PW'(bus_addr - PC_LO)] <= bus_wdata[12 +: FW];
        end
      end
    end
  end
endmodule

// File: rtl/sio_chain_ctrl_chk.sv
module sio_chain_ctrl_chk #(
  parameter int DIVW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sclk,
  input logic            sld,
  input logic            sdo,
  input logic            ss,
  input logic            ar,
  input logic            cfg_wr,
  input logic            idle,
  input logic [DIVW-1:0] div_eff
);
  logic [15:0] hcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hcnt <= '0;
    else if (sld) hcnt <= hcnt + 16'd1;
    else hcnt <= '0;
  end

  AST_LOAD_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) sld |-> !sclk); // R6
  AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(sld) |-> hcnt == 16'(div_eff)); // R6
  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(sdo)); // R5
  AST_SS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ($past(ss) && $past(ar) && !$past(cfg_wr)) |-> ss); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) idle |-> (!sclk && !sld && !sdo)); // R1
endmodule

bind sio_chain_ctrl sio_chain_ctrl_chk #(.DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sio_clk), .sld(sio_load), .sdo(sio_dout),
  .ss(cfg_ss), .ar(cfg_ar), .cfg_wr(cfg_wr_hit), .idle(in_idle), .div_eff(div_eff)
);

// File: tb/sio_chain_ctrl_test.sv
`timescale 1ns/1ps
module sio_chain_ctrl_test;
  logic clk = 0, rst_n = 0, bus_wr = 0, force1 = 0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sio_clk, sio_dout, sio_din, sio_load;
  int checks = 0, fails = 0, rec_n = 0, ld_n = 0, clash = 0;
  logic rec [512];
  logic [3:0] pv [32];
  logic [31:0] en_m;
  int w_m;

  always #2.5 clk = ~clk;
  assign sio_din = force1 ? 1'b1 : sio_dout;

  sio_chain_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sio_clk(sio_clk), .sio_dout(sio_dout),
    .sio_din(sio_din), .sio_load(sio_load));

  always @(posedge sio_clk) begin
    if (rec_n < 512) rec[rec_n] = sio_dout;
    rec_n = rec_n + 1;
  end
  always @(posedge sio_load) ld_n = ld_n + 1;
  always @(posedge clk) if (sio_clk && sio_load) clash = clash + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic push_ports();
    for (int p = 0; p < 32; p++) begin
      logic [31:0] d;
      d = 32'hFF00_0FFF;
      for (int b = 0; b < 4; b++) begin
        d[12+3*b] = pv[p][b];
        d[13+3*b] = 1'b1;
        d[14+3*b] = ~pv[p][b];
      end
      wr(7'h40 + 7'(p), d);
    end
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(7'h00, d);
      if (!d[3]) break;
    end
    chk(!d[3], tag, d[3], 0);
  endtask

  task automatic fire(input int gap);
    wr(7'h00, 32'(w_m) | 32'h8 | (32'(gap) << 16));
  endtask

  task automatic check_seq(input string tag);
    int idx = 0;
    for (int p = 0; p < 32; p++)
      if (en_m[p])
        for (int b = 0; b <= w_m; b++) begin
          chk(idx < rec_n && rec[idx] == pv[p][b], tag, rec[idx], pv[p][b]);
          idx++;
        end
    chk(rec_n == idx, {tag, " count"}, rec_n, idx);
  endtask

  task automatic check_inputs(input bit all_one, input string tag);
    for (int b = 0; b < 4; b++) begin
      logic [31:0] d, e;
      e = '0;
      for (int p = 0; p < 32; p++)
        if (en_m[p] && b <= w_m) e[p] = all_one ? 1'b1 : pv[p][b];
      rd(7'h08 + 7'(b), d);
      chk(d == e, tag, d, e);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    foreach (pv[i]) pv[i] = '0;
    for (int a = 0; a < 3; a++) begin
      rd(7'(a), d); chk(d == 0, "R1 reg after reset", d, 0);
    end
    rd(7'h08, d); chk(d == 0, "R1 input word after reset", d, 0);
    repeat (20) @(negedge clk);
    chk(!sio_clk && !sio_load && !sio_dout, "R1 serial pins quiet", {sio_clk, sio_load, sio_dout}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(7'h45, 32'hFFFF_FFFF); rd(7'h45, d); chk(d == 32'h00FF_F000, "R3 port word readback", d, 32'h00FF_F000);
    wr(7'h45, 0);
    wr(7'h02, 32'h8000_00A5); rd(7'h02, d); chk(d == 32'h8000_00A5, "R12 enable mask readback", d, 32'h8000_00A5);
    wr(7'h01, 32'h000A_BC00); rd(7'h01, d); chk(d == 32'h000A_BC00, "R5 clock word readback", d, 32'h000A_BC00);
    wr(7'h01, 0);
  endtask

  task automatic t_order();
    int l0;
    en_m = 32'h8000_00A5; w_m = 2;
    for (int p = 0; p < 32; p++)
      for (int b = 0; b < 4; b++) pv[p][b] = ((p * 7 + b * 3) % 5) < 2;
    push_ports();
    wr(7'h02, en_m);
    rec_n = 0; l0 = ld_n;
    fire(0); wait_done("R9 single shot clears");
    check_seq("R2 R4 stream order");
    chk(ld_n - l0 == 1, "R6 one load per burst", ld_n - l0, 1);
    check_inputs(0, "R7 loopback words");
    w_m = 0; rec_n = 0;
    fire(0); wait_done("R9 single shot clears w1");
    check_seq("R2 one bit per port");
  endtask

  task automatic t_div();
    realtime t0, t1, t2;
    en_m = 32'h1; w_m = 3; wr(7'h02, en_m);
    wr(7'h01, 32'h0000_0500);
    fire(0);
    @(posedge sio_clk); t0 = $realtime; @(negedge sio_clk); t1 = $realtime; @(posedge sio_clk); t2 = $realtime;
    chk(int'((t1 - t0) / 5.0) == 3, "R5 high phase div5", int'((t1 - t0) / 5.0), 3);
    chk(int'((t2 - t0) / 5.0) == 5, "R5 period div5", int'((t2 - t0) / 5.0), 5);
    wait_done("R9 clear div5");
    wr(7'h01, 32'h0000_0100);
    fire(0);
    @(posedge sio_clk); t0 = $realtime; @(negedge sio_clk); t1 = $realtime; @(posedge sio_clk); t2 = $realtime;
    chk(int'((t1 - t0) / 5.0) == 1, "R5 high phase floor", int'((t1 - t0) / 5.0), 1);
    chk(int'((t2 - t0) / 5.0) == 2, "R5 period floor", int'((t2 - t0) / 5.0), 2);
    wait_done("R9 clear div1");
  endtask

  task automatic t_load();
    realtime t0, t1;
    wr(7'h01, 32'h0000_0700);
    clash = 0;
    fire(0);
    @(posedge sio_load); t0 = $realtime; @(negedge sio_load); t1 = $realtime;
    chk(int'((t1 - t0) / 5.0) == 7, "R6 load width", int'((t1 - t0) / 5.0), 7);
    wait_done("R9 clear load");
    chk(clash == 0, "R6 clock low during load", clash, 0);
  endtask

  task automatic t_repeat();
    realtime t0, t1;
    logic [31:0] d;
    int l0;
    en_m = 32'h1; w_m = 0; wr(7'h02, en_m);
    wr(7'h01, 32'h0000_0400);
    wr(7'h00, 32'h0003_0004);
    @(negedge sio_load); t0 = $realtime; @(posedge sio_clk); t1 = $realtime;
    chk(int'((t1 - t0) / 5.0) == 18, "R8 repeat gap", int'((t1 - t0) / 5.0), 18);
    wr(7'h00, 32'h0003_000C);
    l0 = ld_n;
    repeat (3) @(negedge sio_load);
    rd(7'h00, d); chk(d[3] == 1'b1, "R10 single shot held", d[3], 1);
    chk(ld_n - l0 >= 3, "R8 bursts repeat", ld_n - l0, 3);
    wr(7'h00, 32'h0000_0000);
    repeat (100) @(negedge clk);
    l0 = ld_n;
    repeat (200) @(negedge clk);
    chk(ld_n == l0, "R8 bursts stop", ld_n, l0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    en_m = 32'h3; w_m = 0; wr(7'h02, en_m);
    wr(7'h01, 32'h0000_0600);
    pv[0] = '0; pv[1] = '0; push_ports();
    fire(0); wait_done("R9 clear hold pre");
    force1 = 1;
    fire(0);
    @(posedge sio_load); repeat (2) @(negedge clk);
    rd(7'h08, d); chk(d == 0, "R7 words hold during load", d, 0);
    wait_done("R9 clear hold");
    check_inputs(1, "R7 words after load");
    force1 = 0;
  endtask

  task automatic t_mid();
    logic [3:0] old [32];
    en_m = 32'hFF; w_m = 3; wr(7'h02, en_m);
    wr(7'h01, 32'h0000_1400);
    for (int p = 0; p < 32; p++) pv[p] = 4'(p * 5 + 3);
    push_ports();
    foreach (old[i]) old[i] = pv[i];
    rec_n = 0;
    fire(0);
    @(posedge sio_clk);
    for (int p = 0; p < 32; p++) pv[p] = ~pv[p];
    push_ports();
    wait_done("R9 clear mid");
    for (int p = 0; p < 32; p++) pv[p] = old[p];
    check_seq("R11 old values this burst");
    for (int p = 0; p < 32; p++) pv[p] = ~old[p];
    wr(7'h01, 32'h0000_0200);
    rec_n = 0;
    fire(0); wait_done("R9 clear next");
    check_seq("R11 new values next burst");
  endtask

  task automatic t_none();
    int l0;
    en_m = 0; w_m = 3; wr(7'h02, 0);
    rec_n = 0; l0 = ld_n;
    fire(0); wait_done("R9 clear empty");
    chk(rec_n == 0, "R4 no clocks when none enabled", rec_n, 0);
    chk(ld_n - l0 == 1, "R4 load only burst", ld_n - l0, 1);
    check_inputs(0, "R7 empty burst words");
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_order();
    t_div();
    t_load();
    t_repeat();
    t_hold();
    t_mid();
    t_none();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule